// File: doc/BRIEF.md
# Wait-Pin Edge Interrupt Controller

This block is the interrupt unit of an external-memory controller. It merges two NAND event sources, a data-buffer event and a transfer-count event, with a parameterised number (2 to 4) of wait-pin inputs. Each wait pin serves as an edge-triggered interrupt source whenever the memory side does not use it to stretch bus cycles. Every wait input is brought into the clock domain by a two-flop synchronizer. The edge that software selects is then detected, and the event is latched into a sticky status register.

Software reaches three word registers through a plain read/write port. These are a pending register with write-1-to-clear semantics, a mask register with the same bit layout, and a configuration register holding one edge-polarity bit per wait pin. A single interrupt output goes high while any pending source is also unmasked.

Top module: `memirq_unit`

## Requirements
- R1: After reset the pending, mask and configuration registers read zero and `irqOut` is low, so every wait pin starts on rising-edge detection.
- R2: Register word index `regAddr` selects pending (0), mask (1) or configuration (2), and index 3 reads zero. In pending and mask, bit 0 is the NAND data-buffer event, bit 1 is the NAND transfer-count event and bit 8+n is wait pin n. Every other bit reads zero and ignores writes.
- R3: A NAND event input that is high at a rising clock edge sets its pending bit at that edge. These sources have no polarity setting.
- R4: Configuration bit 8+n selects the edge for wait pin n: 0 for rising, 1 for falling. Only the selected direction sets pending bit 8+n, and it is set at the third rising clock edge after the input changes.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Pending bits never clear by any other means.
- R6: When a new event and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R7: A pending bit is latched whether or not it is unmasked. `irqOut` is high exactly when some pending bit has its mask bit set.
- R8: Changing a pin's polarity bit while the pin holds its level creates no event.
- R9: Mask and configuration bits read back as written, within the field positions of R2. The configuration register implements only bits 8+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on `regAddr`) |
| nandBufEvt | input | 1 | NAND data-buffer event pulse |
| nandCntEvt | input | 1 | NAND transfer-count event pulse |
| waitIn | input | NUM_WAIT | Asynchronous wait-pin inputs |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Event latching and software write-1-to-clear can land on the same pending bit in the same cycle. The bench provokes this collision for a NAND source by pulsing the event input during the clear write. It provokes it for a wait pin by placing the clear write exactly in the cycle where the synchronized edge is being detected, which is two edges after the input moves. In both cases the bit must read back set. A clear write issued one cycle later is then judged as removing the bit, which shows that the collision, not a missed clear, kept it set.

// File: rtl/memirq_pkg.sv
package memirq_pkg;
  localparam int REG_W     = 32;
  localparam int BUF_BIT   = 0;
  localparam int CNT_BIT   = 1;
  localparam int WAIT_BASE = 8;

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  typedef enum logic [1:0] {
    RD_PEND = 2'd0,
    RD_MASK = 2'd1,
    RD_CFG  = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrPend;
    logic   wrMask;
    logic   wrCfg;
    rdSel_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/memirq_edge_det.sv
module memirq_edge_det (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic fallSel,
  output logic evt
);
  logic [1:0] syncQ;
  logic       prevQ;
  logic       riseHit;
  logic       fallHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pinIn};
      prevQ <= syncQ[1];
    end
  end

  assign riseHit = syncQ[1] & ~prevQ;
  assign fallHit = ~syncQ[1] & prevQ;
  assign evt     = fallSel ? fallHit : riseHit;

  AST_EDGE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    evt |-> (syncQ[1] == !fallSel)) else $error("edge direction"); // R4
endmodule

// File: rtl/memirq_ctrl.sv
module memirq_ctrl
  import memirq_pkg::*;
(
  input  logic        [1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes        = '0;
    strobes.wrPend = regWrEn && (regAddr == ADDR_PEND);
    strobes.wrMask = regWrEn && (regAddr == ADDR_MASK);
    strobes.wrCfg  = regWrEn && (regAddr == ADDR_CFG);
    case (regAddr)
      ADDR_PEND: strobes.rdSel = RD_PEND;
      ADDR_MASK: strobes.rdSel = RD_MASK;
      ADDR_CFG:  strobes.rdSel = RD_CFG;
      default:   strobes.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/memirq_dpath.sv
module memirq_dpath
  import memirq_pkg::*;
#(
  parameter int NUM_WAIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [REG_W-1:0]    wrData,
  input  logic                nandBufEvt,
  input  logic                nandCntEvt,
  input  logic [NUM_WAIT-1:0] waitIn,
  output logic [REG_W-1:0]    rdData,
  output logic                irqOut
);
  localparam int NSRC = 2 + NUM_WAIT;

  logic [NSRC-1:0]     pendQ;
  logic [NSRC-1:0]     maskQ;
  logic [NUM_WAIT-1:0] polQ;
  logic [NUM_WAIT-1:0] waitEvt;
  logic [NSRC-1:0]     evtVec;
  logic [NSRC-1:0]     clrVec;
  logic [NSRC-1:0]     wrSrc;
  logic [NUM_WAIT-1:0] wrPol;

  function automatic logic [REG_W-1:0] spreadSrc(input logic [NSRC-1:0] v);
    logic [REG_W-1:0] w;
    w = '0;
    w[BUF_BIT] = v[0];
    w[CNT_BIT] = v[1];
    for (int i = 0; i < NUM_WAIT; i++) w[WAIT_BASE+i] = v[2+i];
    return w;
  endfunction

  function automatic logic [REG_W-1:0] spreadPol(input logic [NUM_WAIT-1:0] v);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_WAIT; i++) w[WAIT_BASE+i] = v[i];
    return w;
  endfunction

  always_comb begin
    wrSrc    = '0;
    wrSrc[0] = wrData[BUF_BIT];
    wrSrc[1] = wrData[CNT_BIT];
    for (int i = 0; i < NUM_WAIT; i++) begin
      wrSrc[2+i] = wrData[WAIT_BASE+i];
      wrPol[i]   = wrData[WAIT_BASE+i];
    end
  end

  generate
    for (genvar p = 0; p < NUM_WAIT; p++) begin : g_pin
      memirq_edge_det u_det (
        .clk     (clk),
        .rstN    (rstN),
        .pinIn   (waitIn[p]),
        .fallSel (polQ[p]),
        .evt     (waitEvt[p])
      );
    end
  endgenerate

  assign evtVec = {waitEvt, nandCntEvt, nandBufEvt};
  assign clrVec = strobes.wrPend ? wrSrc : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      polQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~clrVec) | evtVec;
      if (strobes.wrMask) maskQ <= wrSrc;
      if (strobes.wrCfg)  polQ  <= wrPol;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_PEND: rdData = spreadSrc(pendQ);
      RD_MASK: rdData = spreadSrc(maskQ);
      RD_CFG:  rdData = spreadPol(polQ);
      default: rdData = '0;
    endcase
  end

  assign irqOut = |(pendQ & maskQ);

  AST_NAND_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    nandBufEvt |=> pendQ[0]) else $error("nand latch"); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((pendQ & $past(evtVec)) == $past(evtVec))) else $error("event wins"); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrPend |=> ((pendQ & $past(clrVec) & ~$past(evtVec)) == '0)) else $error("w1c"); // R5
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(pendQ) & ~$past(clrVec) & ~pendQ) == '0)) else $error("sticky"); // R5
endmodule

// File: rtl/memirq_unit.sv
module memirq_unit
  import memirq_pkg::*;
#(
  parameter int NUM_WAIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic                nandBufEvt,
  input  logic                nandCntEvt,
  input  logic [NUM_WAIT-1:0] waitIn,
  output logic                irqOut
);
  ctlStrobes_t strobes;

  memirq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  memirq_dpath #(.NUM_WAIT(NUM_WAIT)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (regWrData),
    .nandBufEvt (nandBufEvt),
    .nandCntEvt (nandCntEvt),
    .waitIn     (waitIn),
    .rdData     (regRdData),
    .irqOut     (irqOut)
  );

  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MASK && regWrData == '0) |=> !irqOut)
    else $error("mask quiet"); // R7
endmodule

// File: tb/sim_memirq_unit.sv
`timescale 1ns/1ps
module sim_memirq_unit;
  localparam int NW = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic nandBufEvt = 1'b0;
  logic nandCntEvt = 1'b0;
  logic [NW-1:0] waitIn = '0;
  logic irqOut;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memirq_unit #(.NUM_WAIT(NW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setWait(input logic [NW-1:0] v);
    @(negedge clk);
    waitIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearAll();
    regWrite(2'd0, 32'hFFFF_FFFF);
  endtask

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] pinBit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      regRead(a[1:0], rd); check("R1 reset reg", rd, 32'h0);
    end
    check("R1 reset irq", {31'b0, irqOut}, 32'h0);

    // R2 / R9 layout and read-back
    regWrite(2'd1, 32'hFFFF_FFFF); regRead(2'd1, rd); check("R9 mask readback", rd, 32'h0000_0F03);
    regWrite(2'd2, 32'hFFFF_FFFF); regRead(2'd2, rd); check("R9 cfg readback", rd, 32'h0000_0F00);
    regWrite(2'd1, 32'h0000_0A02); regRead(2'd1, rd); check("R9 mask pattern", rd, 32'h0000_0A02);
    regWrite(2'd0, 32'hFFFF_FFFF); regRead(2'd0, rd); check("R2 pend not writable", rd, 32'h0);
    regWrite(2'd3, 32'hFFFF_FFFF); regRead(2'd3, rd); check("R2 index3 reads zero", rd, 32'h0);
    regWrite(2'd2, 32'h0); regWrite(2'd1, 32'h0);

    // R4 latency: set at third edge after change
    @(negedge clk); waitIn = 4'b0001;
    repeat (2) @(negedge clk);
    regAddr = 2'd0; #1 check("R4 not yet after two edges", regRdData, 32'h0);
    @(negedge clk); #1 check("R4 set at third edge", regRdData, 32'h0000_0100);
    setWait(4'b0000); clearAll();

    // R4 sweep: each pin and polarity, both directions
    for (int p = 0; p < NW; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        pinBit = 32'h1 << (8 + p);
        regWrite(2'd2, pol ? pinBit : 32'h0);
        clearAll();
        setWait(4'(1 << p));
        regRead(2'd0, rd); check("R4 rising edge", rd, pol ? 32'h0 : pinBit);
        clearAll();
        setWait(4'b0000);
        regRead(2'd0, rd); check("R4 falling edge", rd, pol ? pinBit : 32'h0);
        clearAll();
      end
    end

    // R4 multi-pin sweep, rising then falling
    regWrite(2'd2, 32'h0);
    for (int pat = 1; pat < 16; pat++) begin
      setWait(4'(pat));
      regRead(2'd0, rd); check("R4 multi rising", rd, 32'(pat) << 8);
      clearAll(); setWait(4'b0000);
      regRead(2'd0, rd); check("R4 multi no fall event", rd, 32'h0);
    end
    regWrite(2'd2, 32'h0000_0F00);
    setWait(4'hF); clearAll();
    for (int pat = 1; pat < 16; pat++) begin
      setWait(4'hF & ~4'(pat));
      regRead(2'd0, rd); check("R4 multi falling", rd, 32'(pat) << 8);
      clearAll(); setWait(4'hF);
      regRead(2'd0, rd); check("R4 multi no rise event", rd, 32'h0);
    end

    // R8 polarity change at steady level
    regWrite(2'd2, 32'h0); clearAll();
    repeat (3) @(negedge clk);
    regRead(2'd0, rd); check("R8 no event on polarity flip", rd, 32'h0);
    setWait(4'h0); clearAll();
    regWrite(2'd2, 32'h0000_0F00);
    repeat (3) @(negedge clk);
    regRead(2'd0, rd); check("R8 no event on polarity flip low", rd, 32'h0);
    regWrite(2'd2, 32'h0);

    // R3 NAND pulses
    @(negedge clk); nandBufEvt = 1'b1; @(negedge clk); nandBufEvt = 1'b0;
    regRead(2'd0, rd); check("R3 buffer event", rd, 32'h1);
    @(negedge clk); nandCntEvt = 1'b1; @(negedge clk); nandCntEvt = 1'b0;
    regRead(2'd0, rd); check("R3 count event", rd, 32'h3);

    // R5 write-1-to-clear
    regWrite(2'd0, 32'h0); regRead(2'd0, rd); check("R5 zero write keeps", rd, 32'h3);
    regWrite(2'd0, 32'h1); regRead(2'd0, rd); check("R5 clears only bit0", rd, 32'h2);
    regWrite(2'd0, 32'h2); regRead(2'd0, rd); check("R5 clears bit1", rd, 32'h0);

    // R7 pending regardless of mask; irq = pending & mask
    @(negedge clk); nandBufEvt = 1'b1; nandCntEvt = 1'b1; @(negedge clk); nandBufEvt = 1'b0; nandCntEvt = 1'b0;
    setWait(4'hF);
    regRead(2'd0, rd); check("R7 latched while masked", rd, 32'h0000_0F03);
    check("R7 irq low when masked", {31'b0, irqOut}, 32'h0);
    for (int s = 0; s < 2 + NW; s++) begin
      pinBit = (s < 2) ? (32'h1 << s) : (32'h1 << (6 + s));
      regWrite(2'd1, pinBit); #1 check("R7 single source irq", {31'b0, irqOut}, 32'h1);
      regWrite(2'd0, pinBit); #1 check("R7 irq drops after clear", {31'b0, irqOut}, 32'h0);
    end
    regWrite(2'd1, 32'hFFFF_FFFF); #1 check("R7 nothing pending", {31'b0, irqOut}, 32'h0);
    setWait(4'h0); regWrite(2'd1, 32'h0);

    // R6 collision: NAND event and clear in the same cycle
    @(negedge clk); nandBufEvt = 1'b1; regAddr = 2'd0; regWrData = 32'h1; regWrEn = 1'b1;
    @(negedge clk); nandBufEvt = 1'b0; regWrEn = 1'b0;
    regRead(2'd0, rd); check("R6 nand event wins", rd, 32'h1);
    clearAll(); regRead(2'd0, rd); check("R6 later clear removes", rd, 32'h0);

    // R6 collision: wait edge detection and clear in the same cycle
    @(negedge clk); waitIn = 4'b0100;
    @(negedge clk);
    @(negedge clk); regAddr = 2'd0; regWrData = 32'h0000_0400; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    regRead(2'd0, rd); check("R6 wait event wins", rd, 32'h0000_0400);
    clearAll(); regRead(2'd0, rd); check("R6 wait later clear", rd, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule